// File: doc/BRIEF.md
# Branch and Loop Decision Unit

This unit settles, one operation at a time, whether a control transfer is taken. For a conditional jump it evaluates a four-bit condition code against the zero, sign, overflow and carry flags, covering equality, signed ordering, unsigned ordering, overflow and sign tests. For a counted loop it decrements the supplied count, returns the new count with a write-enable, and takes the branch only while that new count is non-zero, optionally gated by the zero flag. The unit never computes a target address, never fetches, and has no flag outputs, so a loop cannot disturb the flags.

An operation is presented with `in_valid` high for one cycle together with its fields. The verdict appears on the next clock edge as a single-cycle `res_valid` pulse carrying `res_taken`, `res_count` and `res_count_we`. The unit takes a new operation on every cycle and holds no queue. Its result cannot be stalled, so a consumer must take each pulse in the cycle it appears, and a producer may issue back to back with no gaps.

Top module: `bld_unit`

## Requirements
- R1: While reset is held and after its release, `res_valid`, `res_taken` and `res_count_we` are 0 until an operation is issued.
- R2: Each cycle with `in_valid` high produces exactly one `res_valid` pulse on the following cycle. A cycle with `in_valid` low produces no pulse on the following cycle, and `res_taken` and `res_count_we` are 0 whenever `res_valid` is 0.
- R3: With `op_kind`=0, codes 1 (equal) and 2 (not equal) are taken on ZF=1 and ZF=0 respectively; code 11 is taken on OF=1 and 12 on OF=0; code 13 is taken on SF=1 and 14 on SF=0.
- R4: With `op_kind`=0, the signed codes are: 3 (greater) taken when ZF=0 and SF=OF; 4 (greater or equal) taken when SF=OF; 5 (less) taken when SF differs from OF; 6 (less or equal) taken when ZF=1 or SF differs from OF.
- R5: With `op_kind`=0, the unsigned codes are: 7 (above) taken when CF=0 and ZF=0; 8 (above or equal) taken when CF=0; 9 (below) taken when CF=1; 10 (below or equal) taken when CF=1 or ZF=1.
- R6: With `op_kind`=0, code 0 is always taken and code 15 is never taken, for every flag value.
- R7: For any loop kind (`op_kind` 1, 2 or 3), `res_count` equals `count_in` minus one modulo 2^CNT_W, and the branch is blocked whenever that value is zero; a count of 1 is therefore not taken, and a count of 0 wraps to all ones.
- R8: `op_kind`=1 is taken exactly when the decremented count is non-zero; `op_kind`=2 also requires ZF=1; `op_kind`=3 also requires ZF=0.
- R9: `res_count_we` is 1 on a result pulse exactly when the operation was a loop kind, and 0 for conditional jumps.
- R10: For loop kinds, `cond_code` and the SF, OF and CF flags have no effect on `res_taken` or `res_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 conditional jump, 1 loop, 2 loop while ZF=1, 3 loop while ZF=0 |
| cond_code | input | 4 | Condition code for conditional jumps |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_cf | input | 1 | Carry flag |
| count_in | input | CNT_W | Current loop count |
| res_valid | output | 1 | One-cycle result pulse |
| res_taken | output | 1 | Branch taken verdict |
| res_count | output | CNT_W | Decremented count (loop) or passed-through count (jump) |
| res_count_we | output | 1 | Count write-enable, loops only |

## Verification
In a loop that tests the zero flag, the count decrement and the branch verdict are produced in the same cycle, and the verdict depends on both the new count and ZF, so a count of 1 must write 0 and suppress the branch even when ZF would allow it. The bench provokes this by issuing every loop kind with counts 0, 1, 2 and all-ones under both ZF values and with scrambled condition codes, and judges the written count, its enable and the verdict of each pulse against a scoreboard entry. It also issues conditional jumps and loops back to back, so that a loop result with its write-enable and a jump result with none appear on consecutive cycles, and the scoreboard checks that each pulse carries only its own operation's outputs.

// File: rtl/bld_pkg.sv
package bld_pkg;

  typedef enum logic [1:0] {
    OP_JCC    = 2'd0,
    OP_LOOP   = 2'd1,
    OP_LOOPZ  = 2'd2,
    OP_LOOPNZ = 2'd3
  } bld_op_e;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,
    CC_EQ     = 4'd1,
    CC_NE     = 4'd2,
    CC_SGT    = 4'd3,
    CC_SGE    = 4'd4,
    CC_SLT    = 4'd5,
    CC_SLE    = 4'd6,
    CC_UGT    = 4'd7,
    CC_UGE    = 4'd8,
    CC_ULT    = 4'd9,
    CC_ULE    = 4'd10,
    CC_OV     = 4'd11,
    CC_NOV    = 4'd12,
    CC_NEG    = 4'd13,
    CC_POS    = 4'd14,
    CC_NEVER  = 4'd15
  } bld_cc_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
    logic cf;
  } bld_flags_t;

endpackage

// File: rtl/bld_cond_eval.sv
module bld_cond_eval
  import bld_pkg::*;
(
  input  bld_flags_t flags,
  input  bld_cc_e    cc,
  output logic       hit
);

  logic signed_less;
  logic unsigned_le;

  assign signed_less = flags.sf ^ flags.of;
  assign unsigned_le = flags.cf | flags.zf;

  always_comb begin
    case (cc)
      CC_ALWAYS: hit = 1'b1;
      CC_EQ:     hit = flags.zf;
      CC_NE:     hit = ~flags.zf;
      CC_SGT:    hit = ~flags.zf & ~signed_less;
      CC_SGE:    hit = ~signed_less;
      CC_SLT:    hit = signed_less;
      CC_SLE:    hit = flags.zf | signed_less;
      CC_UGT:    hit = ~unsigned_le;
      CC_UGE:    hit = ~flags.cf;
      CC_ULT:    hit = flags.cf;
      CC_ULE:    hit = unsigned_le;
      CC_OV:     hit = flags.of;
      CC_NOV:    hit = ~flags.of;
      CC_NEG:    hit = flags.sf;
      CC_POS:    hit = ~flags.sf;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bld_loop_ctl.sv
module bld_loop_ctl
  import bld_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  bld_op_e          op,
  input  logic             zf,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cnt_dec,
  output logic             is_loop,
  output logic             hit
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic remain;

  assign cnt_dec = cnt_in - STEP;
  assign remain  = |cnt_dec;
  assign is_loop = (op != OP_JCC);

  always_comb begin
    case (op)
      OP_LOOP:   hit = remain;
      OP_LOOPZ:  hit = remain & zf;
      OP_LOOPNZ: hit = remain & ~zf;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/bld_unit.sv
module bld_unit
  import bld_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_kind,
  input  logic [3:0]       cond_code,
  input  logic             flag_zf,
  input  logic             flag_sf,
  input  logic             flag_of,
  input  logic             flag_cf,
  input  logic [CNT_W-1:0] count_in,
  output logic             res_valid,
  output logic             res_taken,
  output logic [CNT_W-1:0] res_count,
  output logic             res_count_we
);

  bld_op_e          op_e;
  bld_cc_e          cc_e;
  bld_flags_t       flags;
  logic             cc_hit;
  logic             loop_hit;
  logic             is_loop;
  logic [CNT_W-1:0] cnt_dec;
  logic             taken_nx;
  logic [CNT_W-1:0] cnt_nx;

  assign op_e  = bld_op_e'(op_kind);
  assign cc_e  = bld_cc_e'(cond_code);
  assign flags = '{zf: flag_zf, sf: flag_sf, of: flag_of, cf: flag_cf};

  bld_cond_eval u_cond (
    .flags (flags),
    .cc    (cc_e),
    .hit   (cc_hit)
  );

  bld_loop_ctl #(.CNT_W(CNT_W)) u_loop (
    .op      (op_e),
    .zf      (flag_zf),
    .cnt_in  (count_in),
    .cnt_dec (cnt_dec),
    .is_loop (is_loop),
    .hit     (loop_hit)
  );

  assign taken_nx = is_loop ? loop_hit : cc_hit;
  assign cnt_nx   = is_loop ? cnt_dec  : count_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_taken    <= 1'b0;
      res_count_we <= 1'b0;
      res_count    <= '0;
    end else begin
      res_valid    <= in_valid;
      res_taken    <= in_valid & taken_nx;
      res_count_we <= in_valid & is_loop;
      if (in_valid) res_count <= cnt_nx;
    end
  end

endmodule

// File: rtl/bld_unit_chk.sv
module bld_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_kind,
  input logic [3:0]       cond_code,
  input logic             flag_zf,
  input logic [CNT_W-1:0] count_in,
  input logic             res_valid,
  input logic             res_taken,
  input logic [CNT_W-1:0] res_count,
  input logic             res_count_we
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_taken && !res_count_we));

  assert_pulse_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  assert_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd0 && cond_code == 4'd0) |=> res_taken);

  assert_never_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd0 && cond_code == 4'd15) |=> !res_taken);

  assert_loop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind != 2'd0) |=> (res_count == CNT_W'($past(count_in) - CNT_W'(1))));

  assert_zero_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count_we && res_count == '0) |-> !res_taken);

  assert_loopz_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd2 && !flag_zf) |=> !res_taken);

  assert_loopnz_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd3 && flag_zf) |=> !res_taken);

  assert_we_loop_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_count_we == ($past(op_kind) != 2'd0)));

endmodule

bind bld_unit bld_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .op_kind      (op_kind),
  .cond_code    (cond_code),
  .flag_zf      (flag_zf),
  .count_in     (count_in),
  .res_valid    (res_valid),
  .res_taken    (res_taken),
  .res_count    (res_count),
  .res_count_we (res_count_we)
);

// File: tb/bld_unit_bench.sv
module bld_unit_bench;

  localparam int CW = 16;

  typedef struct {
    bit          taken;
    bit          we;
    logic [CW-1:0] cnt;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    op_kind = '0;
  logic [3:0]    cond_code = '0;
  logic          flag_zf = 1'b0, flag_sf = 1'b0, flag_of = 1'b0, flag_cf = 1'b0;
  logic [CW-1:0] count_in = '0;
  logic          res_valid, res_taken, res_count_we;
  logic [CW-1:0] res_count;

  int   total = 0;
  int   bad = 0;
  bit   run_mon = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  bld_unit #(.CNT_W(CW)) u_bld_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .cond_code(cond_code), .flag_zf(flag_zf), .flag_sf(flag_sf),
    .flag_of(flag_of), .flag_cf(flag_cf), .count_in(count_in),
    .res_valid(res_valid), .res_taken(res_taken), .res_count(res_count),
    .res_count_we(res_count_we)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit cc_model(int cc, bit z, bit s, bit o, bit c);
    case (cc)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return !z && (s == o);
      4: return s == o;
      5: return s != o;
      6: return z || (s != o);
      7: return !c && !z;
      8: return !c;
      9: return c;
      10: return c || z;
      11: return o;
      12: return !o;
      13: return s;
      14: return !s;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cc_req(int cc);
    if (cc == 0 || cc == 15) return "R6";
    if (cc >= 3 && cc <= 6) return "R4";
    if (cc >= 7 && cc <= 10) return "R5";
    return "R3";
  endfunction

  task automatic issue(int kind, int cc, bit z, bit s, bit o, bit c,
                       logic [CW-1:0] cnt, bit et, bit ew, logic [CW-1:0] ec, string req);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    op_kind   = kind[1:0];
    cond_code = cc[3:0];
    flag_zf = z; flag_sf = s; flag_of = o; flag_cf = c;
    count_in  = cnt;
    e.taken = et; e.we = ew; e.cnt = ec; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      cond_code = 4'hA;
      count_in  = 16'h1234;
    end
  endtask

  task automatic issue_loop(int kind, int cc, bit z, bit s, logic [CW-1:0] cnt);
    logic [CW-1:0] d;
    bit t;
    d = cnt - 16'd1;
    t = (d != 0) && (kind == 1 || (kind == 2 && z) || (kind == 3 && !z));
    issue(kind, cc, z, s, !s, cc[0], cnt, t, 1'b1, d,
          (d == 0) ? "R7" : ((kind == 1) ? "R10" : "R8"));
  endtask

  task automatic issue_cmp(logic [7:0] a, logic [7:0] b);
    logic [7:0] r;
    bit z, s, o, c;
    r = a - b;
    z = (r == 0);
    s = r[7];
    o = (a[7] != b[7]) && (r[7] != a[7]);
    c = (a < b);
    issue(0, 3, z, s, o, c, 0, $signed(a) > $signed(b), 0, 0, "R4");
    issue(0, 4, z, s, o, c, 0, $signed(a) >= $signed(b), 0, 0, "R4");
    issue(0, 5, z, s, o, c, 0, $signed(a) < $signed(b), 0, 0, "R4");
    issue(0, 6, z, s, o, c, 0, $signed(a) <= $signed(b), 0, 0, "R4");
    issue(0, 7, z, s, o, c, 0, a > b, 0, 0, "R5");
    issue(0, 8, z, s, o, c, 0, a >= b, 0, 0, "R5");
    issue(0, 9, z, s, o, c, 0, a < b, 0, 0, "R5");
    issue(0, 10, z, s, o, c, 0, a <= b, 0, 0, "R5");
    issue(0, 1, z, s, o, c, 0, a == b, 0, 0, "R3");
  endtask

  // monitor: scoreboard pop and compare, and pulse accounting (R2)
  always @(posedge clk) begin
    #2;
    if (run_mon) begin
      check(res_valid == (sb.size() > 0), "R2", "res_valid", res_valid, sb.size() > 0);
      if (!res_valid)
        check(!res_taken && !res_count_we, "R2", "idle outputs", {res_taken, res_count_we}, 0);
      if (res_valid && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(res_taken == e.taken, e.req, "taken", res_taken, e.taken);
        check(res_count_we == e.we, "R9", "count_we", res_count_we, e.we);
        if (e.we) check(res_count == e.cnt, e.req, "count", res_count, e.cnt);
      end
    end
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!res_valid && !res_taken && !res_count_we, "R1", "in reset",
          {res_valid, res_taken, res_count_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!res_valid && !res_taken && !res_count_we, "R1", "after reset",
          {res_valid, res_taken, res_count_we}, 0);
    run_mon = 1'b1;

    // R3 R4 R5 R6: every code under every flag pattern, back to back
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        issue(0, cc, f[3], f[2], f[1], f[0], 16'(f), cc_model(cc, f[3], f[2], f[1], f[0]),
              1'b0, '0, cc_req(cc));
    idle(3);

    // R4 R5: flags produced by 8-bit comparisons
    issue_cmp(8'd1, 8'd2);
    issue_cmp(8'hFE, 8'd127);
    issue_cmp(8'd2, 8'd1);
    issue_cmp(8'd127, 8'hFF);
    issue_cmp(8'd2, 8'd2);
    issue_cmp(8'h80, 8'h01);
    issue_cmp(8'h00, 8'hFF);
    idle(2);

    // R7 R8 R10: loops, zero-count boundary and wrap, ZF gating, ignored fields
    for (int k = 1; k < 4; k++)
      for (int z = 0; z < 2; z++)
        for (int cc = 0; cc < 16; cc += 5) begin
          issue_loop(k, cc, z[0], cc[1], 16'd1);
          issue_loop(k, cc, z[0], cc[1], 16'd0);
          issue_loop(k, cc, z[0], cc[1], 16'd2);
          issue_loop(k, cc, z[0], cc[1], 16'hFFFF);
          issue_loop(k, cc, z[0], cc[1], 16'd37);
        end
    idle(1);

    // R9: loop and jump results on consecutive cycles, with gaps between pairs
    for (int i = 0; i < 6; i++) begin
      issue(2, 15, 1, 0, 0, 0, 16'd5, 1'b1, 1'b1, 16'd4, "R8");
      issue(0, 0, 0, 1, 1, 1, 16'd5, 1'b1, 1'b0, '0, "R9");
      issue(3, 0, 1, 0, 0, 0, 16'd9, 1'b0, 1'b1, 16'd8, "R8");
      idle(i % 3);
    end
    idle(4);

    run_mon = 1'b0;
    check(sb.size() == 0, "R2", "pending results", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule